// File: doc/BRIEF.md
# Per-channel DMA interrupt status bank

This block keeps two interrupt flags, A and B, for each channel of a multi-channel DMA engine. It merges them into one interrupt request line. When a channel finishes a descriptor, the channel engine pulses that channel's exhaust line. It also presents the descriptor's two configuration bits, which pick flag A, flag B, both or neither. The chosen flags stay set until software clears them.

Software reaches the block through a small synchronous register port. The port has a word address, a write strobe, write data and registered read data. Through it, software reads both flag vectors and clears flags by writing ones. It also manages a per-channel enable mask through separate set and clear addresses. A flag reaches the request line only if its channel is enabled. The request line is registered.

Top module: `dma_irq_bank`

## Requirements
- R1: While `rst` is high, both flag vectors, the enable mask, `irq` and `rd_data` are held at 0.
- R2: At a clock edge where `exhaust[n]` is 1, flag A of channel n becomes 1 if `cfg_a[n]` is 1, and flag B of channel n becomes 1 if `cfg_b[n]` is 1. If `exhaust[n]` is 0, or the matching configuration bit is 0, that flag is not set.
- R3: If a set event and a write-1 clear hit the same flag bit at the same edge, the flag ends up 1.
- R4: A write to address 0 clears every flag A bit whose `wr_data` bit is 1, and a write to address 1 does the same for flag B. Flag bits whose `wr_data` bit is 0 are unchanged.
- R5: The `wr_data` bits at and above NCH (bits 31:22 by default) have no effect on any write. On every read they return 0.
- R6: A write to address 3 sets every enable bit whose `wr_data` bit is 1. A write to address 4 clears every enable bit whose `wr_data` bit is 1. Reading address 2 returns the enable mask.
- R7: `irq` is 1 exactly one cycle after a cycle in which some channel has (flag A or flag B) and its enable bit set.
- R8: `rd_data` is registered. The value after an edge reflects the register selected by `addr` as it was before that edge. Addresses 5 to 7 read as 0.
- R9: A clear write to one flag vector leaves the other flag vector and the enable mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exhaust | input | NCH | Per-channel pulse: descriptor exhausted |
| cfg_a | input | NCH | Per-channel descriptor bit requesting flag A |
| cfg_b | input | NCH | Per-channel descriptor bit requesting flag B |
| addr | input | AW | Register word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Registered read data |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The assertions assume that `rst` is high from time zero for at least one edge. They also assume that `exhaust`, `cfg_a` and `cfg_b` are valid at every clock edge, with no handshake. They do not assume that set and clear events are exclusive, so the bench mixes random exhaust pulses with random clear writes aimed at the same bits. Random addresses span the full 3-bit space, including the unused words, and random write data fills the reserved upper bits as well.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NCH_DEF = 22;
  localparam int DW_DEF  = 32;
  localparam int AW_DEF  = 3;

  // Register word addresses
  localparam int A_FLAG_A = 0;
  localparam int A_FLAG_B = 1;
  localparam int A_EN_RD  = 2;
  localparam int A_EN_SET = 3;
  localparam int A_EN_CLR = 4;

  localparam int NFLAG = 2;
endpackage

// File: rtl/irq_flag_vec.sv
module irq_flag_vec #(
  parameter int NCH      = 22,
  parameter int AW       = 3,
  parameter int CLR_ADDR = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_i,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [NCH-1:0] wr_bits,
  output logic [NCH-1:0] flags_o
);
  logic [NCH-1:0] clr;

  always_comb begin
    clr = '0;
    if (wr_en && addr == AW'(CLR_ADDR)) clr = wr_bits;
  end

  // Set has priority over clear on the same bit
  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= (flags_o & ~clr) | set_i;
  end

  p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr != '0) |=> ((flags_o & $past(clr & ~set_i)) == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (clr == '0 && set_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NCH      = 22,
  parameter int AW       = 3,
  parameter int SET_ADDR = 3,
  parameter int CLR_ADDR = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [NCH-1:0] wr_bits,
  output logic [NCH-1:0] en_o
);
  logic do_set, do_clr;

  assign do_set = wr_en && addr == AW'(SET_ADDR);
  assign do_clr = wr_en && addr == AW'(CLR_ADDR);

  always_ff @(posedge clk) begin
    if (rst)         en_o <= '0;
    else if (do_set) en_o <= en_o | wr_bits;
    else if (do_clr) en_o <= en_o & ~wr_bits;
  end

  p_en_set_r6: assert property (@(posedge clk) disable iff (rst)
    do_set |=> ((en_o & $past(wr_bits)) == $past(wr_bits)));

  p_en_clr_r6: assert property (@(posedge clk) disable iff (rst)
    do_clr |=> ((en_o & $past(wr_bits)) == '0));
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int NCH = NCH_DEF,
  parameter int DW  = DW_DEF,
  parameter int AW  = AW_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] exhaust,
  input  logic [NCH-1:0] cfg_a,
  input  logic [NCH-1:0] cfg_b,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data,
  output logic           irq
);
  localparam int PADW = DW - NCH;

  logic [NFLAG-1:0][NCH-1:0] flag;
  logic [NFLAG-1:0][NCH-1:0] set_ev;
  logic [NCH-1:0]            en;
  logic [NCH-1:0]            wbits;
  logic                      unused_hi;

  assign wbits     = wr_data[NCH-1:0];
  assign unused_hi = ^wr_data[DW-1:NCH];
  assign set_ev[0] = exhaust & cfg_a;
  assign set_ev[1] = exhaust & cfg_b;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    irq_flag_vec #(
      .NCH(NCH), .AW(AW), .CLR_ADDR(A_FLAG_A + g)
    ) u_vec (
      .clk(clk), .rst(rst), .set_i(set_ev[g]),
      .wr_en(wr_en), .addr(addr), .wr_bits(wbits),
      .flags_o(flag[g])
    );
  end

  irq_enable_reg #(
    .NCH(NCH), .AW(AW), .SET_ADDR(A_EN_SET), .CLR_ADDR(A_EN_CLR)
  ) u_en (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_bits(wbits), .en_o(en)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |((flag[0] | flag[1]) & en);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (addr)
        AW'(A_FLAG_A): rd_data <= {{PADW{1'b0}}, flag[0]};
        AW'(A_FLAG_B): rd_data <= {{PADW{1'b0}}, flag[1]};
        AW'(A_EN_RD):  rd_data <= {{PADW{1'b0}}, en};
        default:       rd_data <= '0;
      endcase
    end
  end

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (rst)
    irq == $past(((flag[0] | flag[1]) & en) != '0));

  p_unused_read_r8: assert property (@(posedge clk) disable iff (rst)
    (addr > AW'(A_EN_CLR)) |=> (rd_data == '0));
endmodule

// File: tb/test_dma_irq_bank.sv
module test_dma_irq_bank;
  localparam int NCH = 22;
  localparam int DW  = 32;
  localparam int AW  = 3;
  localparam time TCLK = 10ns;
  localparam int WDOG = 100000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] exhaust = '0, cfg_a = '0, cfg_b = '0;
  logic [AW-1:0]  addr = '0;
  logic           wr_en = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic [DW-1:0]  rd_data;
  logic           irq;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [NCH-1:0] ma = '0, mb = '0, men = '0;

  always #(TCLK/2) clk = ~clk;

  dma_irq_bank #(.NCH(NCH), .DW(DW), .AW(AW)) i_dma_irq_bank (
    .clk(clk), .rst(rst), .exhaust(exhaust), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    case (a)
      3'd0: return {{(DW-NCH){1'b0}}, ma};
      3'd1: return {{(DW-NCH){1'b0}}, mb};
      3'd2: return {{(DW-NCH){1'b0}}, men};
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [AW-1:0] a);
    if (a > 3'd4) return "R8";
    if (a == 3'd2) return "R6";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, advance one edge, check at the next negedge
  task automatic step(input logic [NCH-1:0] ex, input logic [NCH-1:0] ca,
                      input logic [NCH-1:0] cb, input logic [AW-1:0] a,
                      input logic we, input logic [DW-1:0] wd, input string tag);
    logic [DW-1:0] erd;
    logic eirq;
    logic [NCH-1:0] w;
    exhaust = ex; cfg_a = ca; cfg_b = cb; addr = a; wr_en = we; wr_data = wd;
    erd  = exp_read(a);
    eirq = |((ma | mb) & men);
    w    = wd[NCH-1:0];
    ma  = (ma & ~((we && a == 3'd0) ? w : '0)) | (ex & ca);
    mb  = (mb & ~((we && a == 3'd1) ? w : '0)) | (ex & cb);
    if (we && a == 3'd3) men = men | w;
    else if (we && a == 3'd4) men = men & ~w;
    @(negedge clk);
    check({tag, "/", rd_tag(a)}, rd_data, erd);
    check({tag, "/R7"}, {31'd0, irq}, {31'd0, eirq});
    exhaust = '0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step('0, '0, '0, a, 1'b0, '0, tag);
  endtask

  initial begin
    #(TCLK * WDOG);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    addr = 3'd0;
    repeat (3) @(negedge clk);
    // R1: reset state, with stimulus active
    exhaust = '1; cfg_a = '1; cfg_b = '1;
    @(negedge clk);
    check("R1 rd_data", rd_data, '0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    exhaust = '0; cfg_a = '0; cfg_b = '0;
    rst = 1'b0;
    rd(3'd0, "R1 flagA"); rd(3'd1, "R1 flagB"); rd(3'd2, "R1 enable");

    // R2: selective set
    step(22'h000003, 22'h000001, 22'h000002, 3'd0, 1'b0, '0, "R2");
    step('0, 22'h000010, 22'h000010, 3'd0, 1'b0, '0, "R2 no exhaust");
    step(22'h200004, 22'h200004, 22'h200000, 3'd0, 1'b0, '0, "R2 both");
    rd(3'd0, "R2 A"); rd(3'd1, "R2 B");

    // R6 / R7: enable and irq
    rd(3'd0, "R7 idle");
    step('0, '0, '0, 3'd3, 1'b1, 32'h0000_0002, "R6 set");
    rd(3'd2, "R6 read"); rd(3'd2, "R7 on");
    step('0, '0, '0, 3'd4, 1'b1, 32'h0000_0002, "R6 clr");
    rd(3'd2, "R6 read2"); rd(3'd2, "R7 off");

    // R3: set and clear collide on channel 5
    step(22'h000020, 22'h000020, '0, 3'd0, 1'b1, 32'h0000_0020, "R3");
    rd(3'd0, "R3 read");

    // R4 / R9: clear A leaves B and enable
    step('0, '0, '0, 3'd3, 1'b1, 32'h003F_FFFF, "R9 en");
    step('0, '0, '0, 3'd0, 1'b1, 32'h0000_0001, "R4 clrA");
    rd(3'd0, "R4 A"); rd(3'd1, "R9 B"); rd(3'd2, "R9 en");

    // R5: reserved bits only
    step('0, '0, '0, 3'd0, 1'b1, 32'hFFC0_0000, "R5 A");
    step('0, '0, '0, 3'd4, 1'b1, 32'hFFC0_0000, "R5 en");
    rd(3'd0, "R5 A"); rd(3'd2, "R5 en");

    // R8: unused addresses
    step('0, '0, '0, 3'd5, 1'b1, 32'hFFFF_FFFF, "R8 w5");
    rd(3'd6, "R8"); rd(3'd7, "R8"); rd(3'd1, "R8 B");

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [NCH-1:0] ex, ca, cb;
      ex = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      ca = NCH'($urandom);
      cb = NCH'($urandom);
      step(ex, ca, cb, AW'($urandom_range(0, 7)), ($urandom_range(0, 1) == 1),
           $urandom, "R2/R3 rnd");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule